// File: doc/BRIEF.md
# Low-Error Truncated Array Multiplier

This block multiplies two N-bit operands and returns only the upper N bits of the 2N-bit product, in a single combinational pass. The array keeps the partial-product terms whose weight is at least 2^N. Terms below column N-1 are never formed, and no adder cells are spent on them. The N terms of column N-1 are kept out of the adder array. They are paired, and each pair yields one estimated carry that enters column N. This recovers most of the value lost by truncation, at the cost of N/2 small gates.

A parameter selects unsigned magnitude arithmetic or two's-complement arithmetic. In two's-complement mode, every term that pairs a sign bit with a non-sign bit is inverted. A constant is added to correct for those inversions, and the pair cells become plain OR gates over the inverted terms. The block is meant for datapaths that keep a fixed word width from stage to stage, such as filters and scaling stages. N is even, from 4 to 16, and defaults to 6.

Top module: `fw_lowerr_mult`

## Requirements
- R1: In magnitude mode, p equals (K + C) mod 2^N. K is the sum over all bit pairs with i+j >= N of x[i]&y[j]·2^(i+j-N). C is the number of set pair carries.
- R2: In magnitude mode, there is one pair carry for each m in 0..N/2-1. That carry is (x[N-1-2m]&y[2m]) | (x[N-2-2m]&y[2m+1]), a single AND-OR cell per pair.
- R3: In magnitude mode, the signed error p - floor(x·y / 2^N), taken mod 2^N, lies in [-(N-1), N/2] for every operand pair.
- R4: In two's-complement mode, a term t(i,j) = x[i]&y[j] is inverted exactly when one, but not both, of i and j equals N-1. Then p = (K' + C' + 1 + 2^(N-1)) mod 2^N. K' is the weighted sum of the kept terms t(i,j) with i+j >= N.
- R5: In two's-complement mode, pair carry m is t(N-1-2m, 2m) | t(N-2-2m, 2m+1). The end terms t(N-1,0) and t(0,N-1) are therefore inverted before the OR.
- R6: In two's-complement mode, the signed error p - floor(X·Y / 2^N) lies in [-(N-1), N/2] for every operand pair. Here X and Y are the signed operands, and the error is taken mod 2^N.
- R7: In magnitude mode, a zero operand on either input gives p = 0.
- R8: In two's-complement mode, x = y = -2^(N-1) gives p = 2^(N-2) + 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | N | Multiplicand (unsigned or two's complement per ARITH) |
| y | input | N | Multiplier (unsigned or two's complement per ARITH) |
| p | output | N | Upper N bits of the compensated product |

## Verification
The pair carries and, in two's-complement mode, the sign-correction constant and the inverted sign-row terms all land in column N in the same evaluation. A carry that is mishandled there is hidden unless both sources are active together. The sweep covers every operand pair at N = 6 in both modes. This includes the most-negative operands, where every inverted term and both inverted end terms of column N-1 are set. Each output is compared exactly against the arithmetic sum defined in R1 and R4, and the error against the true high product is held to the window in R3 and R6.

// File: rtl/fwm_pkg.sv
package fwm_pkg;

    typedef enum logic {
        FWM_MAG  = 1'b0,
        FWM_TWOS = 1'b1
    } fwm_arith_e;

    // A term is complemented when it pairs a sign bit with a non-sign bit
    function automatic logic flip_term(int i, int j, int n, fwm_arith_e arith);
        return (arith == FWM_TWOS) && ((i == n - 1) != (j == n - 1));
    endfunction

    // Number of estimated carries produced from column n-1
    function automatic int pair_count(int n);
        return n / 2;
    endfunction

endpackage

// File: rtl/fwm_pp_gen.sv
module fwm_pp_gen
    import fwm_pkg::*;
#(
    parameter int         N     = 6,
    parameter fwm_arith_e ARITH = FWM_MAG
) (
    input  logic [N-1:0]         x,
    input  logic [N-1:0]         y,
    output logic [N-1:0][N-1:0]  kcol,
    output logic [N-1:0]         diag
);
    // kcol[c] holds the terms of product column N+c; unused slots are zero
    for (genvar c = 0; c < N; c++) begin : g_col
        for (genvar r = 0; r < N; r++) begin : g_row
            if (r < N - 1 - c) begin : g_term
                localparam int   I   = c + 1 + r;
                localparam int   J   = N + c - I;
                localparam logic INV = flip_term(I, J, N, ARITH);
                assign kcol[c][r] = (x[I] & y[J]) ^ INV;
            end else begin : g_pad
                assign kcol[c][r] = 1'b0;
            end
        end
    end

    // Column N-1 terms, k-th one pairs x[N-1-k] with y[k]
    for (genvar k = 0; k < N; k++) begin : g_diag
        localparam int   DI   = N - 1 - k;
        localparam logic DINV = flip_term(DI, k, N, ARITH);
        assign diag[k] = (x[DI] & y[k]) ^ DINV;
    end

endmodule

// File: rtl/fwm_comp.sv
module fwm_comp
    import fwm_pkg::*;
#(
    parameter int         N     = 6,
    parameter fwm_arith_e ARITH = FWM_MAG
) (
    input  logic [N-1:0]   x,
    input  logic [N-1:0]   y,
    input  logic [N-1:0]   diag,
    output logic [N/2-1:0] carry
);
    localparam int PAIRS = pair_count(N);

    if (ARITH == FWM_MAG) begin : g_andor
        // One AND-OR cell per pair, built straight from the operand bits
        for (genvar m = 0; m < PAIRS; m++) begin : g_cell
            assign carry[m] = (x[N-1-2*m] & y[2*m]) | (x[N-2-2*m] & y[2*m+1]);
        end
    end else begin : g_or
        // Terms are already sign-corrected; an OR per pair suffices
        for (genvar m = 0; m < PAIRS; m++) begin : g_cell
            assign carry[m] = diag[2*m] | diag[2*m+1];
        end
    end

    // R2/R5: each pair carry covers at least half and at most all set terms
    always_comb begin
        a_r2_carry_floor: assert ($countones(carry) >= ($countones(diag) + 1) / 2)
            else $error("R2: fewer pair carries than half the column terms");
        a_r5_carry_ceiling: assert ($countones(carry) <= $countones(diag))
            else $error("R5: more pair carries than column terms");
    end

endmodule

// File: rtl/fwm_col_sum.sv
module fwm_col_sum
    import fwm_pkg::*;
#(
    parameter int         N     = 6,
    parameter fwm_arith_e ARITH = FWM_MAG
) (
    input  logic [N-1:0][N-1:0] kcol,
    input  logic [N/2-1:0]      carry,
    output logic [N-1:0]        p
);
    localparam int PAIRS = pair_count(N);
    localparam logic [N-1:0] SIGN_FIX = (ARITH == FWM_TWOS) ?
        (N'(1) + (N'(1) << (N - 1))) : '0;

    logic [N-1:0] acc;

    // Column-compression sum, kept modulo 2^N since only N bits leave
    always_comb begin
        acc = SIGN_FIX;
        for (int c = 0; c < N; c++) begin
            acc = acc + (N'($countones(kcol[c])) << c);
        end
        for (int m = 0; m < PAIRS; m++) begin
            acc = acc + N'(carry[m]);
        end
    end

    assign p = acc;

endmodule

// File: rtl/fw_lowerr_mult.sv
module fw_lowerr_mult
    import fwm_pkg::*;
#(
    parameter int         N     = 6,
    parameter fwm_arith_e ARITH = FWM_MAG
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    output logic [N-1:0] p
);
    localparam int HALF = pair_count(N);

    logic [N-1:0][N-1:0] kcol;
    logic [N-1:0]        diag;
    logic [HALF-1:0]     carry;

    fwm_pp_gen #(.N(N), .ARITH(ARITH)) u_pp (
        .x    (x),
        .y    (y),
        .kcol (kcol),
        .diag (diag)
    );

    fwm_comp #(.N(N), .ARITH(ARITH)) u_comp (
        .x     (x),
        .y     (y),
        .diag  (diag),
        .carry (carry)
    );

    fwm_col_sum #(.N(N), .ARITH(ARITH)) u_sum (
        .kcol  (kcol),
        .carry (carry),
        .p     (p)
    );

    // Error window against the true upper half of the product
    logic [N-1:0] hi_ref;
    int           err_i;

    if (ARITH == FWM_MAG) begin : g_ref_mag
        assign hi_ref = N'(({{N{1'b0}}, x} * {{N{1'b0}}, y}) >> N);
    end else begin : g_ref_twos
        assign hi_ref = N'(($signed({{N{x[N-1]}}, x}) * $signed({{N{y[N-1]}}, y})) >>> N);
    end

    always_comb begin
        err_i = int'($signed(p - hi_ref));
        if (ARITH == FWM_MAG) begin
            a_r3_err_window: assert (err_i >= -(N - 1) && err_i <= N / 2)
                else $error("R3: magnitude error %0d outside window", err_i);
            a_r7_zero_operand: assert (!(x == '0 || y == '0) || p == '0)
                else $error("R7: zero operand gave nonzero output");
        end else begin
            a_r6_err_window: assert (err_i >= -(N - 1) && err_i <= N / 2)
                else $error("R6: signed error %0d outside window", err_i);
            a_r8_min_square: assert (!(x == (N'(1) << (N - 1)) && y == (N'(1) << (N - 1)))
                                     || p == (N'(1) << (N - 2)) + N'(1))
                else $error("R8: most-negative square gave wrong output");
        end
    end

endmodule

// File: tb/fw_lowerr_mult_bench.sv
module fw_lowerr_mult_bench;
    import fwm_pkg::*;

    localparam int N = 6;
    localparam int M = 1 << N;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [N-1:0] xa;
    logic [N-1:0] ya;
    logic [N-1:0] p_mag;
    logic [N-1:0] p_tc;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    fw_lowerr_mult #(.N(N), .ARITH(FWM_MAG)) u_fw_lowerr_mult (
        .x (xa), .y (ya), .p (p_mag)
    );

    fw_lowerr_mult #(.N(N), .ARITH(FWM_TWOS)) u_fw_lowerr_mult_tc (
        .x (xa), .y (ya), .p (p_tc)
    );

    function automatic int tbit(int a, int b, int i, int j, bit tc);
        int t = ((a >> i) & (b >> j)) & 1;
        if (tc && ((i == N - 1) != (j == N - 1))) t = t ^ 1;
        return t;
    endfunction

    // Output defined by R1/R2 (tc=0) and R4/R5 (tc=1)
    function automatic int model(int a, int b, bit tc);
        int k = 0;
        int c = 0;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (i + j >= N) k += tbit(a, b, i, j, tc) << (i + j - N);
        for (int m = 0; m < N / 2; m++)
            c += tbit(a, b, N - 1 - 2 * m, 2 * m, tc) | tbit(a, b, N - 2 - 2 * m, 2 * m + 1, tc);
        if (tc) k += 1 + (1 << (N - 1));
        return (k + c) & (M - 1);
    endfunction

    function automatic int exact_hi(int a, int b, bit tc);
        int sa;
        int sb;
        if (!tc) return (a * b) >> N;
        sa = (a >= M / 2) ? a - M : a;
        sb = (b >= M / 2) ? b - M : b;
        return ((sa * sb) >>> N) & (M - 1);
    endfunction

    function automatic int sdiff(int pv, int hv);
        int d = (pv - hv) & (M - 1);
        if (d >= M / 2) d -= M;
        return d;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (x=%0d y=%0d)", req, act, exp, xa, ya);
        end
    endtask

    task automatic check_win(string req, int e);
        checks++;
        if (e < -(N - 1) || e > N / 2) begin
            errors++;
            $display("FAIL %s: actual error %0d expected within [%0d,%0d] (x=%0d y=%0d)",
                     req, e, -(N - 1), N / 2, xa, ya);
        end
    endtask

    task automatic apply(int a, int b);
        @(posedge clk);
        #1;
        xa = N'(a);
        ya = N'(b);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        xa = '0;
        ya = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // Idle state: zero operands
        check("R7 idle zero", int'(p_mag), 0);
        check("R4 idle zero", int'(p_tc), model(0, 0, 1'b1));

        // R7: one operand zero, the other busy
        apply(M - 1, 0);
        check("R7 y zero", int'(p_mag), 0);
        apply(0, 45);
        check("R7 x zero", int'(p_mag), 0);

        // R1: all-ones magnitude operands, worked by hand: 57 kept + 3 carries
        apply(M - 1, M - 1);
        check("R1 all ones", int'(p_mag), 60);

        // R8: most-negative square
        apply(M / 2, M / 2);
        check("R8 min square", int'(p_tc), (1 << (N - 2)) + 1);

        // Exhaustive sweep of both modes
        for (int a = 0; a < M; a++) begin
            for (int b = 0; b < M; b++) begin
                apply(a, b);
                check("R1/R2 magnitude value", int'(p_mag), model(a, b, 1'b0));
                check_win("R3 magnitude error", sdiff(int'(p_mag), exact_hi(a, b, 1'b0)));
                check("R4/R5 twos value", int'(p_tc), model(a, b, 1'b1));
                check_win("R6 twos error", sdiff(int'(p_tc), exact_hi(a, b, 1'b1)));
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule